// File: doc/BRIEF.md
# Locked Swap Sequencer

This block carries out one atomic exchange with memory. It reads a location and then writes the same location, and no other master can get between the two accesses. A decode stage hands it the swap instruction word, the base address and the source register value that the register file returned for that instruction, and a flag that selects a word or a byte exchange. The block runs a read request and then a write request on a simple request/acknowledge memory port. A lock output stays high across both requests so that an external arbiter keeps the bus. When the write has been acknowledged, the block returns the loaded value, the index of the destination register and the data-cycle cost of the whole exchange.

For a word exchange the loaded word is rotated right by the byte offset of the address, which gives the usual result for a misaligned word load. For a byte exchange only the low byte of the source goes out, and the loaded byte comes back zero-extended. The cost reported for the write phase equals the cost of the read phase, so the reported cost is twice the read cost. The block handles one exchange at a time. A start request made while an exchange is in flight is dropped.

Top module: `swap_seq`

## Requirements
- R1: After reset the block is idle: mem_req_o, mem_lock_o and done_o are low and result_o is zero.
- R2: A start request in idle leads to a read (mem_we_o low) at base_addr_i on the following cycle. The write to the same address begins in the cycle after the read acknowledge and never before it.
- R3: mem_lock_o is high from the first cycle of the read request up to and including the cycle in which the write is acknowledged, with no gap between the two phases. It is low in the done cycle.
- R4: In a word exchange (byte_i low, so mem_byte_o low) the write data is the full source word. result_o is the read data rotated right by 8 times base address bits 1:0.
- R5: In a byte exchange (byte_i high, so mem_byte_o high in both phases) the write data holds source bits 7:0 in bits 7:0 with zeros above them. result_o is read-data bits 7:0, zero-extended.
- R6: cost_o equals twice the value on mem_cyc_i in the cycle of the read acknowledge. The value on mem_cyc_i at the write acknowledge has no effect.
- R7: rf_base_idx_o is instr_i bits 19:16 and rf_src_idx_o is instr_i bits 3:0, both combinational. dst_idx_o is instr_i bits 15:12 as captured at the accepted start.
- R8: done_o is a one-cycle pulse in the cycle after the write acknowledge. result_o, dst_idx_o and cost_o are valid in that cycle.
- R9: A start request while an exchange is in flight is ignored. It changes neither the address nor the write data of the current exchange, and it does not start a second exchange.
- R10: While a request waits for its acknowledge, mem_addr_o, mem_we_o and mem_wdata_o stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin an exchange |
| instr_i | input | 32 | Swap instruction word |
| byte_i | input | 1 | High selects a byte exchange |
| base_addr_i | input | 32 | Address to exchange with |
| src_data_i | input | 32 | Value to be stored |
| rf_base_idx_o | output | 4 | Register index of the base address |
| rf_src_idx_o | output | 4 | Register index of the source value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | High for the write phase |
| mem_byte_o | output | 1 | High for byte-size accesses |
| mem_lock_o | output | 1 | Bus lock across both phases |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Request acknowledged |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_cyc_i | input | 4 | Data-cycle cost reported with acknowledge |
| done_o | output | 1 | Exchange complete pulse |
| result_o | output | 32 | Loaded value for the destination |
| dst_idx_o | output | 4 | Destination register index |
| cost_o | output | 5 | Data-cycle cost of the exchange |

## Verification
Two of the block's actions can land in the same cycle: a fresh start request, and the in-flight exchange's own acknowledge or write phase. The bench raises start_i with a different instruction, address and source while the write is still waiting for its acknowledge. It then judges that the write address and data, the returned destination index and the done pulse all belong to the first exchange, and that no read follows the done cycle. A second such case puts a changed mem_cyc_i on the write acknowledge and expects the reported cost to come from the read acknowledge alone.

// File: rtl/swap_pkg.sv
package swap_pkg;
    localparam int IDX_W      = 4;
    localparam int BASE_LSB   = 16;
    localparam int DST_LSB    = 12;
    localparam int SRC_LSB    = 0;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } swap_state_e;
endpackage

// File: rtl/swp_field_dec.sv
module swp_field_dec
    import swap_pkg::*;
#(
    parameter int IW = 32
) (
    input  logic [IW-1:0]    instr_i,
    output logic [IDX_W-1:0] base_idx_o,
    output logic [IDX_W-1:0] src_idx_o,
    output logic [IDX_W-1:0] dst_idx_o
);
    assign base_idx_o = instr_i[BASE_LSB +: IDX_W];
    assign src_idx_o  = instr_i[SRC_LSB  +: IDX_W];
    assign dst_idx_o  = instr_i[DST_LSB  +: IDX_W];
endmodule

// File: rtl/swp_load_align.sv
module swp_load_align #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]            rdata_i,
    input  logic [$clog2(DW/8)-1:0]  off_i,
    input  logic                     byte_i,
    output logic [DW-1:0]            value_o
);
    localparam int LANES = DW / 8;

    logic [DW-1:0] rot [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_rot
        if (g == 0) begin : g_zero
            assign rot[g] = rdata_i;
        end else begin : g_shift
            assign rot[g] = {rdata_i[8*g-1:0], rdata_i[DW-1:8*g]};
        end
    end

    always_comb begin
        if (byte_i) value_o = {{(DW-8){1'b0}}, rdata_i[7:0]};
        else        value_o = rot[off_i];
    end
endmodule

// File: rtl/swap_seq.sv
module swap_seq
    import swap_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int IW    = 32,
    parameter int CYC_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [IW-1:0]      instr_i,
    input  logic               byte_i,
    input  logic [AW-1:0]      base_addr_i,
    input  logic [DW-1:0]      src_data_i,
    output logic [IDX_W-1:0]   rf_base_idx_o,
    output logic [IDX_W-1:0]   rf_src_idx_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic               mem_byte_o,
    output logic               mem_lock_o,
    output logic [AW-1:0]      mem_addr_o,
    output logic [DW-1:0]      mem_wdata_o,
    input  logic               mem_ack_i,
    input  logic [DW-1:0]      mem_rdata_i,
    input  logic [CYC_W-1:0]   mem_cyc_i,
    output logic               done_o,
    output logic [DW-1:0]      result_o,
    output logic [IDX_W-1:0]   dst_idx_o,
    output logic [CYC_W:0]     cost_o
);
    localparam int OFF_W = $clog2(DW / 8);

    typedef struct packed {
        swap_state_e      state;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    wdata;
        logic             bmode;
        logic [IDX_W-1:0] dst;
        logic [DW-1:0]    result;
        logic [CYC_W:0]   cost;
    } regs_t;

    regs_t r_q, r_d;

    logic [IDX_W-1:0] dec_dst;
    logic [DW-1:0]    aligned;

    swp_field_dec #(.IW(IW)) u_dec (
        .instr_i    (instr_i),
        .base_idx_o (rf_base_idx_o),
        .src_idx_o  (rf_src_idx_o),
        .dst_idx_o  (dec_dst)
    );

    swp_load_align #(.DW(DW)) u_align (
        .rdata_i (mem_rdata_i),
        .off_i   (r_q.addr[OFF_W-1:0]),
        .byte_i  (r_q.bmode),
        .value_o (aligned)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_READ;
                    r_d.addr  = base_addr_i;
                    r_d.bmode = byte_i;
                    r_d.dst   = dec_dst;
                    r_d.wdata = byte_i ? {{(DW-8){1'b0}}, src_data_i[7:0]}
                                       : src_data_i;
                end
            end
            ST_READ: begin
                if (mem_ack_i) begin
                    r_d.state  = ST_WRITE;
                    r_d.result = aligned;
                    r_d.cost   = {1'b0, mem_cyc_i} << 1;
                end
            end
            ST_WRITE: begin
                if (mem_ack_i) r_d.state = ST_DONE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_o   = (r_q.state == ST_READ) || (r_q.state == ST_WRITE);
    assign mem_we_o    = (r_q.state == ST_WRITE);
    assign mem_lock_o  = mem_req_o;
    assign mem_byte_o  = r_q.bmode;
    assign mem_addr_o  = r_q.addr;
    assign mem_wdata_o = r_q.wdata;
    assign done_o      = (r_q.state == ST_DONE);
    assign result_o    = r_q.result;
    assign dst_idx_o   = r_q.dst;
    assign cost_o      = r_q.cost;

    // R2: the write phase opens only right after a read acknowledge
    a_r2_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o && mem_we_o) |-> $past(mem_req_o && !mem_we_o && mem_ack_i));

    // R3: lock carries over from the read acknowledge into the write
    a_r3_lock_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o && mem_ack_i) |=> (mem_lock_o && mem_req_o && mem_we_o));

    // R3: lock released in the done cycle
    a_r3_lock_off_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !mem_lock_o);

    // R5: byte writes carry nothing above the low byte
    a_r5_byte_wdata: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && mem_byte_o) |-> (mem_wdata_o[DW-1:8] == '0));

    // R6: a doubled cost is always even
    a_r6_cost_even: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cost_o[0]);

    // R8: done lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: a waiting request holds its address, direction and data
    a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> ($stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
endmodule

// File: tb/swap_seq_tb_top.sv
`timescale 1ns/1ps
module swap_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [31:0] instr_i;
    logic        byte_i;
    logic [31:0] base_addr_i;
    logic [31:0] src_data_i;
    logic [3:0]  rf_base_idx_o, rf_src_idx_o, dst_idx_o;
    logic        mem_req_o, mem_we_o, mem_byte_o, mem_lock_o, done_o;
    logic [31:0] mem_addr_o, mem_wdata_o, result_o;
    logic        mem_ack_i;
    logic [31:0] mem_rdata_i;
    logic [3:0]  mem_cyc_i;
    logic [4:0]  cost_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    swap_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .byte_i(byte_i), .base_addr_i(base_addr_i), .src_data_i(src_data_i),
        .rf_base_idx_o(rf_base_idx_o), .rf_src_idx_o(rf_src_idx_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_byte_o(mem_byte_o),
        .mem_lock_o(mem_lock_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .mem_cyc_i(mem_cyc_i),
        .done_o(done_o), .result_o(result_o), .dst_idx_o(dst_idx_o), .cost_o(cost_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_load(input logic [31:0] rd, input logic [1:0] off, input bit b);
        logic [63:0] dbl;
        if (b) return {24'h0, rd[7:0]};
        dbl = {rd, rd} >> (8 * off);
        return dbl[31:0];
    endfunction

    // one full exchange; busy_hit raises a competing start during the write wait
    task automatic do_swap(input logic [31:0] instr, input logic [31:0] base,
                           input logic [31:0] src, input bit b,
                           input logic [31:0] rd, input int rd_wait, input int wr_wait,
                           input logic [3:0] rcyc, input logic [3:0] wcyc, input bit busy_hit);
        logic [31:0] wexp;
        wexp = b ? {24'h0, src[7:0]} : src;
        @(negedge clk);
        start_i = 1'b1; instr_i = instr; base_addr_i = base; src_data_i = src; byte_i = b;
        #0.5;
        chk("R7 base idx", {28'h0, rf_base_idx_o}, {28'h0, instr[19:16]});
        chk("R7 src idx",  {28'h0, rf_src_idx_o},  {28'h0, instr[3:0]});
        @(negedge clk);
        start_i = 1'b0; instr_i = 32'hFFFF_FFFF; base_addr_i = 32'hDEAD_0000; src_data_i = 32'h5555_5555;
        chk("R2 read req",  {30'h0, mem_req_o, mem_we_o}, 32'h2);
        chk("R3 lock read", {31'h0, mem_lock_o}, 32'h1);
        chk("R2 read addr", mem_addr_o, base);
        chk("R5 size read", {31'h0, mem_byte_o}, {31'h0, b});
        for (int i = 0; i < rd_wait; i++) begin
            @(negedge clk);
            chk("R10 read hold", {29'h0, mem_req_o, mem_we_o, mem_lock_o}, 32'h5);
            chk("R10 read addr", mem_addr_o, base);
        end
        mem_ack_i = 1'b1; mem_rdata_i = rd; mem_cyc_i = rcyc;
        @(negedge clk);
        mem_ack_i = 1'b0; mem_rdata_i = 32'h0; mem_cyc_i = 4'h0;
        chk("R3 lock write", {29'h0, mem_req_o, mem_we_o, mem_lock_o}, 32'h7);
        chk("R2 write addr", mem_addr_o, base);
        chk(b ? "R5 byte wdata" : "R4 word wdata", mem_wdata_o, wexp);
        chk("R5 size write", {31'h0, mem_byte_o}, {31'h0, b});
        if (busy_hit) begin
            start_i = 1'b1; instr_i = 32'h0007_3009; base_addr_i = base + 32'h100;
            src_data_i = ~src; byte_i = ~b;
        end
        for (int i = 0; i < wr_wait; i++) begin
            @(negedge clk);
            chk("R10 write hold", {29'h0, mem_req_o, mem_we_o, mem_lock_o}, 32'h7);
            chk(busy_hit ? "R9 wdata kept" : "R10 wdata", mem_wdata_o, wexp);
            chk(busy_hit ? "R9 addr kept" : "R10 addr", mem_addr_o, base);
        end
        mem_ack_i = 1'b1; mem_cyc_i = wcyc;
        @(negedge clk);
        mem_ack_i = 1'b0; mem_cyc_i = 4'h0; start_i = 1'b0;
        chk("R8 done", {31'h0, done_o}, 32'h1);
        chk("R3 lock off", {30'h0, mem_lock_o, mem_req_o}, 32'h0);
        chk(b ? "R5 byte result" : "R4 word result", result_o, exp_load(rd, base[1:0], b));
        chk("R7 dst idx", {28'h0, dst_idx_o}, {28'h0, instr[15:12]});
        chk("R6 cost", {27'h0, cost_o}, {27'h0, rcyc, 1'b0});
        @(negedge clk);
        chk("R8 done pulse", {31'h0, done_o}, 32'h0);
        chk(busy_hit ? "R9 no second swap" : "R8 idle after", {31'h0, mem_req_o}, 32'h0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start_i = 1'b0; instr_i = '0; byte_i = 1'b0; base_addr_i = '0;
        src_data_i = '0; mem_ack_i = 1'b0; mem_rdata_i = '0; mem_cyc_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req",    {31'h0, mem_req_o},  32'h0);
        chk("R1 lock",   {31'h0, mem_lock_o}, 32'h0);
        chk("R1 done",   {31'h0, done_o},     32'h0);
        chk("R1 result", result_o,            32'h0);
    endtask

    task automatic t_word_aligned();
        do_swap(32'hE103_2091, 32'h0000_1000, 32'hCAFE_BABE, 1'b0, 32'h1122_3344, 0, 0, 4'd1, 4'd9, 1'b0);
    endtask

    task automatic t_word_misaligned();
        do_swap(32'hE10A_5093, 32'h0000_2001, 32'h0BAD_F00D, 1'b0, 32'hA1B2_C3D4, 1, 0, 4'd2, 4'd0, 1'b0);
        do_swap(32'hE10B_6094, 32'h0000_2002, 32'h1234_5678, 1'b0, 32'hA1B2_C3D4, 0, 2, 4'd3, 4'd1, 1'b0);
        do_swap(32'hE10C_7095, 32'h0000_2003, 32'h8765_4321, 1'b0, 32'hA1B2_C3D4, 2, 1, 4'd15, 4'd4, 1'b0);
    endtask

    task automatic t_byte();
        do_swap(32'hE14D_E09F, 32'h0000_3003, 32'hFFFF_FF9C, 1'b1, 32'hEEDD_CCF7, 0, 0, 4'd4, 4'd7, 1'b0);
        do_swap(32'hE140_1092, 32'h0000_3000, 32'h0000_0081, 1'b1, 32'h1234_5680, 3, 3, 4'd6, 4'd2, 1'b0);
    endtask

    task automatic t_busy_start();
        do_swap(32'hE105_8096, 32'h0000_4002, 32'h7777_AAAA, 1'b0, 32'h0102_0304, 1, 3, 4'd5, 4'd11, 1'b1);
    endtask

    initial begin
        t_reset();
        t_word_aligned();
        t_word_misaligned();
        t_byte();
        t_busy_start();
        repeat (2) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule